// File: doc/BRIEF.md
# Merging Store Buffer

This block sits between a write-through cache (or a CPU store port) and the memory. It holds stores that have not yet reached memory, so the producer does not have to wait for the memory to accept each one. Every slot holds one block-aligned address, a full block of data and a mask that marks which bytes are valid. When a store arrives for a block that already has a waiting, mergeable slot, its enabled bytes are written into that slot and no new slot is taken. Otherwise the store opens a new slot at the tail.

Slots leave toward memory strictly in the order they were opened, over a valid/ready handshake that carries the block address, the data and the byte mask. The oldest slot is the one offered to memory, so it is frozen: later stores to its block open a fresh slot behind it. The producer is back-pressured only when every slot is in use. Full and empty flags are exported.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `mem_valid`=0 and `st_ready`=1.
- R2: A store accepted (`st_valid`&&`st_ready`) whose block matches no mergeable slot opens a new slot, and the buffer is not empty in the next cycle.
- R3: With all 4 slots in use, `full`=1 and `st_ready`=0. A store held on `st_valid` while full is not taken and changes no slot.
- R4: A store whose block matches a waiting slot other than the oldest one writes its enabled bytes over that slot's bytes, ORs its enables into the slot's mask and opens no new slot.
- R5: A store whose block matches only the oldest slot (the one offered on the memory side) opens a new slot and leaves the oldest slot unchanged.
- R6: `mem_valid` is high exactly when a slot is in use. Slots go out in the order they were opened. While `mem_valid`=1 and `mem_ready`=0, `mem_blk`, `mem_data` and `mem_mask` hold steady.
- R7: A merge into the second-oldest slot in the same cycle as the oldest slot drains takes full effect. The merged slot is then offered next, with the union mask and the merged bytes.
- R8: A new-slot store in the same cycle as a drain leaves the slot count unchanged, and both slots keep their order.
- R9: Bit i of `mem_mask` is byte i (bits 8i+7..8i of `mem_data`). A byte that no store enabled since the slot opened is driven as zero. A byte enabled by several stores carries the value of the latest one.
- R10: `full` and `empty` track the slot count after each push, merge and drain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be taken this cycle |
| st_blk | input | 27 | Block address of the store |
| st_data | input | 256 | Store data, one byte per lane |
| st_be | input | 32 | Byte enables of the store |
| mem_valid | output | 1 | Oldest slot offered to memory |
| mem_ready | input | 1 | Memory takes the offered slot |
| mem_blk | output | 27 | Block address of the offered slot |
| mem_data | output | 256 | Data of the offered slot |
| mem_mask | output | 32 | Byte-valid mask of the offered slot |
| full | output | 1 | All slots in use |
| empty | output | 1 | No slot in use |

## Verification
The two functions that can fall in the same cycle are a store, either merging or opening a slot, and a drain of the oldest slot. The bench provokes this by raising `mem_ready` and `st_valid` in the same cycle. In one case the store targets the block just behind the head, so the merge lands in the slot that becomes the head. In the other case the store targets a new block. Each is judged by what the memory side offers next and by the order of the drain that follows, which must show the merged bytes, the union mask and an unchanged slot count. A sweep over byte-enable patterns checks the merge arithmetic lane by lane.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    localparam int WB_SLOTS     = 4;
    localparam int WB_BLK_BYTES = 32;
    localparam int WB_BLK_AW    = 27;
    localparam int WB_DATA_W    = WB_BLK_BYTES * 8;

    typedef logic [WB_BLK_AW-1:0]    blk_t;
    typedef logic [WB_DATA_W-1:0]    data_t;
    typedef logic [WB_BLK_BYTES-1:0] mask_t;

    typedef struct packed {
        blk_t  blk;
        data_t data;
        mask_t mask;
    } slot_t;

    function automatic int slot_idx_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wbuf_match.sv
module wbuf_match
    import wbuf_pkg::*;
#(
    parameter int SLOTS = WB_SLOTS,
    localparam int IW   = slot_idx_w(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOTS-1:0]  occ,
    input  blk_t              tags [SLOTS],
    input  logic [IW-1:0]     head,
    input  blk_t              probe,
    output logic              hit,
    output logic [IW-1:0]     hit_idx
);

    logic [SLOTS-1:0] hit_vec;

    // The head slot is on offer to memory and never merges.
    for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
        assign hit_vec[i] = occ[i] && (head != IW'(i)) && (tags[i] == probe);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end

    assign hit = |hit_vec;

    // R4: merging prevents a second mergeable slot for one block
    p_single_match_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge
    import wbuf_pkg::*;
(
    input  slot_t old_slot,
    input  logic  fresh,
    input  blk_t  st_blk,
    input  data_t st_data,
    input  mask_t st_be,
    output slot_t new_slot
);

    for (genvar b = 0; b < WB_BLK_BYTES; b++) begin : g_lane
        always_comb begin
            if (st_be[b])
                new_slot.data[8*b +: 8] = st_data[8*b +: 8];
            else if (fresh)
                new_slot.data[8*b +: 8] = 8'h00;
            else
                new_slot.data[8*b +: 8] = old_slot.data[8*b +: 8];
        end
        assign new_slot.mask[b] = st_be[b] | (!fresh && old_slot.mask[b]);
    end

    assign new_slot.blk = st_blk;

endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
    import wbuf_pkg::*;
#(
    parameter int SLOTS = WB_SLOTS,
    localparam int IW   = slot_idx_w(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [WB_BLK_AW-1:0]    st_blk,
    input  logic [WB_DATA_W-1:0]    st_data,
    input  logic [WB_BLK_BYTES-1:0] st_be,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [WB_BLK_AW-1:0]    mem_blk,
    output logic [WB_DATA_W-1:0]    mem_data,
    output logic [WB_BLK_BYTES-1:0] mem_mask,
    output logic                    full,
    output logic                    empty
);

    slot_t            slots [SLOTS];
    blk_t             tags  [SLOTS];
    logic [SLOTS-1:0] occ;
    logic [IW-1:0]    head, tail;
    logic             hit;
    logic [IW-1:0]    hit_idx, wr_idx;
    logic             st_fire, pop;
    slot_t            upd;

    function automatic logic [IW-1:0] step(logic [IW-1:0] i);
        return (i == IW'(SLOTS - 1)) ? '0 : i + 1'b1;
    endfunction

    for (genvar i = 0; i < SLOTS; i++) begin : g_tag
        assign tags[i] = slots[i].blk;
    end

    wbuf_match #(.SLOTS(SLOTS)) u_match (
        .clk     (clk),
        .rst     (rst),
        .occ     (occ),
        .tags    (tags),
        .head    (head),
        .probe   (st_blk),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    wbuf_merge u_merge (
        .old_slot (slots[hit_idx]),
        .fresh    (!hit),
        .st_blk   (st_blk),
        .st_data  (st_data),
        .st_be    (st_be),
        .new_slot (upd)
    );

    assign full      = &occ;
    assign empty     = ~|occ;
    assign st_ready  = !full;
    assign st_fire   = st_valid && st_ready;
    assign mem_valid = !empty;
    assign pop       = mem_valid && mem_ready;
    assign wr_idx    = hit ? hit_idx : tail;
    assign mem_blk   = slots[head].blk;
    assign mem_data  = slots[head].data;
    assign mem_mask  = slots[head].mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ  <= '0;
            head <= '0;
            tail <= '0;
            for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
        end else begin
            if (pop) begin
                occ[head] <= 1'b0;
                head      <= step(head);
            end
            if (st_fire) begin
                slots[wr_idx] <= upd;
                occ[wr_idx]   <= 1'b1;
                if (!hit) tail <= step(tail);
            end
        end
    end

    // R2: an accepted store always leaves something to drain
    p_alloc_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
        st_fire |=> !empty);

    // R6: offered slot is frozen while memory stalls
    p_head_stable_r6: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_blk)
            && $stable(mem_data) && $stable(mem_mask));

    // R3: without a drain a full buffer stays full
    p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
        full && !pop |=> full);

    // R8: a drain with no store frees a slot
    p_pop_frees_r8: assert property (@(posedge clk) disable iff (rst)
        pop && !st_fire |=> !full);

    // R4: a merge takes no new slot
    p_merge_keeps_tail_r4: assert property (@(posedge clk) disable iff (rst)
        st_fire && hit |=> tail == $past(tail));

endmodule

// File: tb/merge_wbuf_tb.sv
module merge_wbuf_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         st_valid, st_ready;
    logic [26:0]  st_blk;
    logic [255:0] st_data;
    logic [31:0]  st_be;
    logic         mem_valid, mem_ready;
    logic [26:0]  mem_blk;
    logic [255:0] mem_data;
    logic [31:0]  mem_mask;
    logic         full, empty;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    merge_wbuf u_dut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_blk(st_blk),
        .st_data(st_data), .st_be(st_be),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_blk(mem_blk),
        .mem_data(mem_data), .mem_mask(mem_mask),
        .full(full), .empty(empty)
    );

    function automatic logic [255:0] pat(int seed);
        logic [255:0] d;
        for (int i = 0; i < 32; i++) d[8*i +: 8] = 8'(seed * 7 + i * 3 + 1);
        return d;
    endfunction

    // Byte-wise overlay: enabled bytes of nd win, the rest keep od.
    function automatic logic [255:0] overlay(logic [255:0] od, logic [255:0] nd,
                                             logic [31:0] be);
        logic [255:0] r;
        for (int i = 0; i < 32; i++) r[8*i +: 8] = be[i] ? nd[8*i +: 8] : od[8*i +: 8];
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start just after a falling edge.
    task automatic store(logic [26:0] b, logic [255:0] d, logic [31:0] be);
        st_valid = 1'b1; st_blk = b; st_data = d; st_be = be;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic pop_expect(logic [26:0] b, logic [255:0] d, logic [31:0] m, string req);
        check(mem_valid == 1'b1, req, 256'(mem_valid), 256'(1));
        check(mem_blk == b, req, 256'(mem_blk), 256'(b));
        check(mem_mask == m, req, 256'(mem_mask), 256'(m));
        check(mem_data == d, req, mem_data, d);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [255:0] e;
        rst = 1'b1; st_valid = 1'b0; st_blk = '0; st_data = '0; st_be = '0;
        mem_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(empty == 1'b1, "R1 empty", 256'(empty), 256'(1));
        check(full == 1'b0, "R1 full", 256'(full), 256'(0));
        check(mem_valid == 1'b0, "R1 mem_valid", 256'(mem_valid), 256'(0));
        check(st_ready == 1'b1, "R1 st_ready", 256'(st_ready), 256'(1));

        // R2 R4 R5 R9: X, Y, Y merge, X behind locked head
        store(27'd10, pat(1), 32'h0000_000F);
        check(empty == 1'b0, "R2 nonempty", 256'(empty), 256'(0));
        store(27'd20, pat(2), 32'h0000_000F);
        store(27'd20, pat(3), 32'h0000_00FC);
        store(27'd10, pat(4), 32'h0000_0F00);
        check(full == 1'b0, "R4 merge took no slot", 256'(full), 256'(0));
        store(27'd30, pat(5), 32'h1);
        check(full == 1'b1, "R4 R10 fourth slot fills", 256'(full), 256'(1));
        pop_expect(27'd10, overlay('0, pat(1), 32'hF), 32'h0000_000F, "R6 R9 first");
        e = overlay(overlay('0, pat(2), 32'hF), pat(3), 32'hFC);
        pop_expect(27'd20, e, 32'h0000_00FF, "R4 merged");
        pop_expect(27'd10, overlay('0, pat(4), 32'hF00), 32'h0000_0F00, "R5 locked head");
        pop_expect(27'd30, overlay('0, pat(5), 32'h1), 32'h1, "R6 last");
        check(empty == 1'b1, "R10 empty after drain", 256'(empty), 256'(1));

        // R3: fill, hold a fifth store while full, drain exactly four
        for (int i = 0; i < 4; i++) store(27'(40 + i), pat(10 + i), '1);
        check(full == 1'b1, "R3 full", 256'(full), 256'(1));
        check(st_ready == 1'b0, "R3 st_ready", 256'(st_ready), 256'(0));
        st_valid = 1'b1; st_blk = 27'd41; st_data = pat(99); st_be = '1;
        repeat (3) @(negedge clk);
        st_valid = 1'b0;
        // R6: stalled head stays put
        check(mem_blk == 27'd40, "R6 stall blk", 256'(mem_blk), 256'(40));
        for (int i = 0; i < 4; i++) pop_expect(27'(40 + i), pat(10 + i), '1, "R3 R6 order");
        check(empty == 1'b1, "R3 no extra slot", 256'(empty), 256'(1));

        // R7: merge into next slot while head drains
        store(27'd50, pat(20), 32'hFF);
        store(27'd51, pat(21), 32'h00FF_0000);
        st_valid = 1'b1; st_blk = 27'd51; st_data = pat(22); st_be = 32'h0F0F_0000;
        mem_ready = 1'b1;
        @(negedge clk);
        st_valid = 1'b0; mem_ready = 1'b0;
        e = overlay(overlay('0, pat(21), 32'h00FF_0000), pat(22), 32'h0F0F_0000);
        pop_expect(27'd51, e, 32'h0FFF_0000, "R7 merge during drain");
        check(empty == 1'b1, "R7 one slot left", 256'(empty), 256'(1));

        // R8: new slot while head drains
        store(27'd60, pat(30), '1);
        store(27'd61, pat(31), '1);
        st_valid = 1'b1; st_blk = 27'd62; st_data = pat(32); st_be = '1;
        mem_ready = 1'b1;
        @(negedge clk);
        st_valid = 1'b0; mem_ready = 1'b0;
        pop_expect(27'd61, pat(31), '1, "R8 order");
        pop_expect(27'd62, pat(32), '1, "R8 order");
        check(empty == 1'b1, "R8 count kept", 256'(empty), 256'(1));

        // R4 R9 sweep over enable patterns
        for (int t = 0; t < 32; t++) begin
            logic [31:0] b1, b2;
            b1 = 32'hFFFF_FFFF >> t;
            b2 = 32'h1 << t;
            store(27'd100, pat(t), '1);
            store(27'(200 + t), pat(t + 40), b1);
            store(27'(200 + t), pat(t + 80), b2);
            pop_expect(27'd100, pat(t), '1, "R5 sweep head");
            e = overlay(overlay('0, pat(t + 40), b1), pat(t + 80), b2);
            pop_expect(27'(200 + t), e, b1 | b2, "R4 R9 sweep");
        end
        check(empty == 1'b1, "R10 sweep end", 256'(empty), 256'(1));

        finish_run();
    end

endmodule